// File: doc/BRIEF.md
# Arbitrating Interrupt Capture Register

This block gathers service requests from eighteen interrupt sources, nine on each of two serial channels. Every source presents a request flag, an 8-bit bid and an 8-bit byte count. Each cycle, a combinational arbiter finds the highest bid among the requesting sources. On a capture event the block compares that winner against a threshold that the host programs. It then latches an 8-bit current-interrupt word and a byte-count register. If no source qualifies, it latches zeros instead.

There are two kinds of capture event, and both do the same latch operation. One is a host write to the capture address, which is the update command. The other is a falling edge on the asynchronous interrupt-acknowledge input, which is active low. The captured context stays frozen until the next capture event. The host can therefore poll with one write and one read. The captured word also steers two global data paths to the winning channel: a global receive-data read and a global transmit-data write.

Top module: `intr_cap_top`

## Requirements
- R1: After synchronous reset, the captured word, the byte count and the threshold all read as 0.
- R2: A bus write to address 0 captures the highest requesting bid. A bid must be strictly higher to displace another, so on equal bids the lowest source index wins.
- R3: A high-to-low transition on `iack_n` captures exactly as an update write does, at the third rising clock edge after the low level is set up. A low-to-high transition captures nothing.
- R4: When no source qualifies at capture time, the captured word and the byte count both load 0.
- R5: A requesting source qualifies when its bid is strictly greater than the threshold. When the threshold is 0, every requesting source qualifies, including one whose bid is 0.
- R6: The captured word is laid out as type in [7:5], channel in [4] and local source index 0..8 in [3:0]. Source number s is channel s/9, local index s%9. The type is taken from the local index: 0 gives 1 (receive FIFO), 1 gives 2 (transmit FIFO), 2..4 give 3 (character match), 5..6 give 4 (line error), 7..8 give 5 (other). Type 0 means nothing is pending.
- R7: The byte-count register latches the winner's count for types 1 and 2, and 0 for every other type.
- R8: Between capture events, the captured word and the byte count do not change, whatever the inputs do.
- R9: A read of address 5 returns the receive data of the captured channel (`rx_fifo_data` bits [8c+7:8c] for channel c). When the captured type is 0, the read returns 0.
- R10: A write to address 6 pulses `tx_wr_stb[c]` only for the captured channel c, in the same cycle as the write, with `tx_wdata` equal to the write data. When the captured type is 0, no strobe is raised.
- R11: Address 1 holds the threshold and can be written and read back. Address 2 reads the byte count, address 3 reads the type zero-extended, and address 4 reads the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| iack_n | input | 1 | Asynchronous interrupt acknowledge, active low |
| src_req | input | 18 | Request flag per source |
| src_bid | input | 144 | Bid per source, 8 bits each, source s at [8s+7:8s] |
| src_cnt | input | 144 | Byte count per source, 8 bits each |
| rx_fifo_data | input | 16 | Receive data head per channel, 8 bits each |
| tx_wr_stb | output | 2 | Global transmit write strobe per channel |
| tx_wdata | output | 8 | Global transmit write data |

## Verification
The bench targets the points where an arbiter like this usually goes wrong:
- **Ties.** A tie between two sources on different channels exposes an arbiter that uses `>=`, because the higher index would win and the captured channel would flip.
- **Threshold boundary.** A bid equal to the threshold must give a zero capture and a bid one above it must not, which catches an off-by-one comparison. A zero-bid request with threshold 0 catches a design that treats zero as "exceeds nothing".
- **Acknowledge edge.** The capture is sampled on the exact cycle it is due, so a wrong synchroniser depth shows up as early or late latching. A rising edge that captures, or inputs that change while held, show up as a changed word.
- **Empty capture.** After a capture with nothing qualifying, a global read must return 0 and a global write must raise no strobe, which catches a design that still routes to a stale channel.

// File: rtl/intr_cap_pkg.sv
package intr_cap_pkg;
    localparam int NUM_CH     = 2;
    localparam int SRC_PER_CH = 9;
    localparam int NUM_SRC    = NUM_CH * SRC_PER_CH;
    localparam int BID_W      = 8;
    localparam int CNT_W      = 8;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 3;
    localparam int IDX_W      = $clog2(NUM_SRC);
    localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int SUB_W      = 4;

    typedef enum logic [2:0] {
        SVC_NONE = 3'd0,
        SVC_RX   = 3'd1,
        SVC_TX   = 3'd2,
        SVC_CHAR = 3'd3,
        SVC_LINE = 3'd4,
        SVC_MISC = 3'd5
    } svc_e;

    typedef struct packed {
        svc_e             kind;
        logic [CH_W-1:0]  chan;
        logic [SUB_W-1:0] sub;
    } cir_t;

    typedef enum logic [ADDR_W-1:0] {
        REG_CIR  = 3'd0,
        REG_THR  = 3'd1,
        REG_CNT  = 3'd2,
        REG_TYPE = 3'd3,
        REG_CHAN = 3'd4,
        REG_GRX  = 3'd5,
        REG_GTX  = 3'd6
    } reg_addr_e;

    function automatic svc_e kind_of(input logic [SUB_W-1:0] local_idx);
        case (local_idx)
            4'd0:             return SVC_RX;
            4'd1:             return SVC_TX;
            4'd2, 4'd3, 4'd4: return SVC_CHAR;
            4'd5, 4'd6:       return SVC_LINE;
            default:          return SVC_MISC;
        endcase
    endfunction

    function automatic logic carries_count(input svc_e k);
        return (k == SVC_RX) || (k == SVC_TX);
    endfunction
endpackage

// File: rtl/intr_arbiter.sv
module intr_arbiter
    import intr_cap_pkg::*;
#(
    parameter int N  = NUM_SRC,
    parameter int BW = BID_W,
    parameter int CW = CNT_W,
    parameter int IW = IDX_W
) (
    input  logic [N-1:0]    req,
    input  logic [N*BW-1:0] bid,
    input  logic [N*CW-1:0] cnt,
    output logic            any,
    output logic [IW-1:0]   idx,
    output logic [BW-1:0]   best,
    output logic [CW-1:0]   best_cnt
);
    // Linear scan: a later source displaces only with a strictly larger bid,
    // so the lowest index keeps ties.
    always_comb begin
        any      = 1'b0;
        idx      = '0;
        best     = '0;
        best_cnt = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!any || (bid[i*BW +: BW] > best))) begin
                any      = 1'b1;
                idx      = IW'(i);
                best     = bid[i*BW +: BW];
                best_cnt = cnt[i*CW +: CW];
            end
        end
    end
endmodule

// File: rtl/iack_fall_det.sv
module iack_fall_det (
    input  logic clk,
    input  logic rst,
    input  logic iack_n,
    output logic fall
);
    logic s1_q, s2_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= 1'b1;
            s2_q   <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            s1_q   <= iack_n;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    assign fall = prev_q & ~s2_q;
endmodule

// File: rtl/intr_capture.sv
module intr_capture
    import intr_cap_pkg::*;
#(
    parameter int BW = BID_W,
    parameter int CW = CNT_W,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap_evt,
    input  logic          win_any,
    input  logic [IW-1:0] win_idx,
    input  logic [BW-1:0] win_bid,
    input  logic [CW-1:0] win_cnt,
    input  logic [BW-1:0] thr,
    output cir_t          cir_q,
    output logic [CW-1:0] cnt_q
);
    logic qualifies;
    cir_t cir_d;
    logic [CW-1:0] cnt_d;
    int unsigned ix;

    assign qualifies = win_any && ((win_bid > thr) || (thr == '0));

    always_comb begin
        ix    = 32'(win_idx);
        cir_d = '0;
        cnt_d = '0;
        if (qualifies) begin
            cir_d.sub  = SUB_W'(ix % SRC_PER_CH);
            cir_d.chan = CH_W'(ix / SRC_PER_CH);
            cir_d.kind = kind_of(cir_d.sub);
            if (carries_count(cir_d.kind)) cnt_d = win_cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cir_q <= '0;
            cnt_q <= '0;
        end else if (cap_evt) begin
            cir_q <= cir_d;
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/intr_cap_top.sv
module intr_cap_top
    import intr_cap_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    input  logic                     iack_n,
    input  logic [NUM_SRC-1:0]       src_req,
    input  logic [NUM_SRC*BID_W-1:0] src_bid,
    input  logic [NUM_SRC*CNT_W-1:0] src_cnt,
    input  logic [NUM_CH*DATA_W-1:0] rx_fifo_data,
    output logic [NUM_CH-1:0]        tx_wr_stb,
    output logic [DATA_W-1:0]        tx_wdata
);
    logic             win_any;
    logic [IDX_W-1:0] win_idx;
    logic [BID_W-1:0] win_bid;
    logic [CNT_W-1:0] win_cnt;
    logic             iack_fall;
    logic             cap_evt;
    logic [BID_W-1:0] thr_q;
    cir_t             cir_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ctx_live;

    intr_arbiter u_arb (
        .req(src_req), .bid(src_bid), .cnt(src_cnt),
        .any(win_any), .idx(win_idx), .best(win_bid), .best_cnt(win_cnt)
    );

    iack_fall_det u_iack (.clk(clk), .rst(rst), .iack_n(iack_n), .fall(iack_fall));

    assign cap_evt = (bus_wr && (bus_addr == REG_CIR)) || iack_fall;

    intr_capture u_cap (
        .clk(clk), .rst(rst), .cap_evt(cap_evt),
        .win_any(win_any), .win_idx(win_idx), .win_bid(win_bid), .win_cnt(win_cnt),
        .thr(thr_q), .cir_q(cir_q), .cnt_q(cnt_q)
    );

    always_ff @(posedge clk) begin
        if (rst)                                   thr_q <= '0;
        else if (bus_wr && (bus_addr == REG_THR))  thr_q <= bus_wdata;
    end

    assign ctx_live = (cir_q.kind != SVC_NONE);
    assign tx_wdata = bus_wdata;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_tx
        assign tx_wr_stb[c] = bus_wr && (bus_addr == REG_GTX) && ctx_live
                              && (cir_q.chan == CH_W'(c));
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_CIR:  bus_rdata = DATA_W'(cir_q);
            REG_THR:  bus_rdata = thr_q;
            REG_CNT:  bus_rdata = cnt_q;
            REG_TYPE: bus_rdata = DATA_W'(cir_q.kind);
            REG_CHAN: bus_rdata = DATA_W'(cir_q.chan);
            REG_GRX:  if (ctx_live) bus_rdata = rx_fifo_data[cir_q.chan*DATA_W +: DATA_W];
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/intr_cap_chk.sv
module intr_cap_chk
    import intr_cap_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               cap_evt,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [NUM_SRC-1:0] src_req,
    input logic [NUM_CH-1:0]  tx_wr_stb,
    input cir_t               cir_q,
    input logic [CNT_W-1:0]   cnt_q,
    input logic [BID_W-1:0]   thr_q
);
    AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cap_evt |=> ($stable(cir_q) && $stable(cnt_q))); // R8

    AST_EMPTY_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (cap_evt && (src_req == '0)) |=> ((cir_q == '0) && (cnt_q == '0))); // R4

    AST_TX_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tx_wr_stb)); // R10

    AST_TX_NEEDS_CTX: assert property (@(posedge clk) disable iff (rst)
        (tx_wr_stb != '0) |-> (cir_q.kind != SVC_NONE)); // R10

    AST_TYPE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        cir_q.kind <= SVC_MISC); // R6

    AST_COUNT_KIND: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |-> ((cir_q.kind == SVC_RX) || (cir_q.kind == SVC_TX))); // R7

    AST_THR_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (bus_addr == REG_THR)) |=> (thr_q == $past(bus_wdata))); // R11
endmodule

bind intr_cap_top intr_cap_chk u_chk (
    .clk(clk), .rst(rst), .cap_evt(cap_evt), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .src_req(src_req), .tx_wr_stb(tx_wr_stb),
    .cir_q(cir_q), .cnt_q(cnt_q), .thr_q(thr_q)
);

// File: tb/test_intr_cap_top.sv
module test_intr_cap_top;
    localparam int NS = 18;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        iack_n = 1'b1;
    logic [NS-1:0]   src_req = '0;
    logic [NS*8-1:0] src_bid = '0;
    logic [NS*8-1:0] src_cnt = '0;
    logic [15:0] rx_fifo_data = '0;
    logic [1:0]  tx_wr_stb;
    logic [7:0]  tx_wdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    logic [7:0] thr_m = '0;

    always #5 clk = ~clk;

    intr_cap_top i_intr_cap_top (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .iack_n(iack_n),
        .src_req(src_req), .src_bid(src_bid), .src_cnt(src_cnt),
        .rx_fifo_data(rx_fifo_data), .tx_wr_stb(tx_wr_stb), .tx_wdata(tx_wdata)
    );

    task automatic check(input string rq, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", rq, act, exp);
        end
    endtask

    // Expected capture computed from R2, R4..R7.
    function automatic logic [15:0] model();
        logic found = 0;
        int   w = 0;
        logic [7:0] wb = 0;
        logic [7:0] word;
        logic [7:0] cnt;
        int loc;
        logic [2:0] ty;
        for (int s = 0; s < NS; s++)
            if (src_req[s] && (!found || src_bid[s*8 +: 8] > wb)) begin
                found = 1; w = s; wb = src_bid[s*8 +: 8];
            end
        if (!found || !(wb > thr_m || thr_m == 0)) return 16'h0;
        loc = w % 9;
        ty  = (loc == 0) ? 3'd1 : (loc == 1) ? 3'd2 : (loc <= 4) ? 3'd3 : (loc <= 6) ? 3'd4 : 3'd5;
        word = {ty, 1'(w / 9), 4'(loc)};
        cnt  = (ty == 3'd1 || ty == 3'd2) ? src_cnt[w*8 +: 8] : 8'h0;
        return {word, cnt};
    endfunction

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 3'd1) thr_m = d;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_src(input int s, input logic [7:0] b, input logic [7:0] c);
        src_req[s] = 1'b1;
        src_bid[s*8 +: 8] = b;
        src_cnt[s*8 +: 8] = c;
    endtask

    task automatic clear_src();
        src_req = '0; src_bid = '0; src_cnt = '0;
    endtask

    task automatic expect_capture(input string rq);
        logic [15:0] e;
        logic [7:0] d;
        e = model();
        bus_read(3'd0, d); check({rq, " word"}, d, e[15:8]);
        bus_read(3'd2, d); check({rq, " count"}, d, e[7:0]);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        bus_read(3'd0, d); check("R1 word", d, 8'h00);
        bus_read(3'd1, d); check("R1 threshold", d, 8'h00);
        bus_read(3'd2, d); check("R1 count", d, 8'h00);
    endtask

    task automatic t_update_basic();
        logic [7:0] d;
        clear_src();
        bus_write(3'd1, 8'h10);
        bus_read(3'd1, d); check("R11 threshold readback", d, 8'h10);
        set_src(3, 8'h40, 8'h07);
        set_src(10, 8'h80, 8'h21);
        bus_write(3'd0, 8'h00);
        bus_read(3'd0, d); check("R2 R6 winner word", d, 8'h51);
        bus_read(3'd2, d); check("R7 fifo count", d, 8'h21);
        bus_read(3'd3, d); check("R11 type", d, 8'h02);
        bus_read(3'd4, d); check("R11 channel", d, 8'h01);
        expect_capture("R2 model");
    endtask

    task automatic t_tie();
        logic [7:0] d;
        clear_src();
        set_src(13, 8'h55, 8'h09);
        set_src(4, 8'h55, 8'h09);
        bus_write(3'd0, 8'h00);
        bus_read(3'd0, d); check("R2 tie lowest index", d, 8'h64);
        bus_read(3'd2, d); check("R7 non-fifo count zero", d, 8'h00);
    endtask

    task automatic t_threshold();
        logic [7:0] d;
        clear_src();
        bus_write(3'd1, 8'h60);
        set_src(16, 8'h60, 8'h00);
        bus_write(3'd0, 8'h00);
        bus_read(3'd0, d); check("R5 bid equal threshold", d, 8'h00);
        src_bid[16*8 +: 8] = 8'h61;
        bus_write(3'd0, 8'h00);
        bus_read(3'd0, d); check("R5 bid above threshold", d, 8'hB7);
        expect_capture("R6 model");
    endtask

    task automatic t_thr_zero();
        logic [7:0] d;
        clear_src();
        bus_write(3'd1, 8'h00);
        set_src(9, 8'h00, 8'h3C);
        bus_write(3'd0, 8'h00);
        bus_read(3'd0, d); check("R5 zero threshold zero bid", d, 8'h30);
        bus_read(3'd2, d); check("R7 rx count", d, 8'h3C);
    endtask

    task automatic t_none();
        logic [7:0] d;
        logic [7:0] s;
        clear_src();
        bus_write(3'd0, 8'h00);
        bus_read(3'd0, d); check("R4 empty word", d, 8'h00);
        bus_read(3'd2, d); check("R4 empty count", d, 8'h00);
        rx_fifo_data = 16'hA5C3;
        bus_read(3'd5, d); check("R9 empty grx", d, 8'h00);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd6; bus_wdata = 8'h77;
        #1 s = {6'h0, tx_wr_stb};
        @(negedge clk);
        bus_wr = 1'b0;
        check("R10 empty no strobe", s, 8'h00);
    endtask

    task automatic t_global();
        logic [7:0] d;
        logic [7:0] s;
        clear_src();
        set_src(1, 8'h20, 8'h05);
        bus_write(3'd0, 8'h00);
        rx_fifo_data = 16'hBE11;
        bus_read(3'd5, d); check("R9 grx ch0", d, 8'h11);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd6; bus_wdata = 8'h9A;
        #1 s = {6'h0, tx_wr_stb};
        check("R10 tx data", tx_wdata, 8'h9A);
        @(negedge clk);
        bus_wr = 1'b0;
        check("R10 strobe ch0", s, 8'h01);
        clear_src();
        set_src(17, 8'h20, 8'h05);
        bus_write(3'd0, 8'h00);
        bus_read(3'd5, d); check("R9 grx ch1", d, 8'hBE);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd6; bus_wdata = 8'h01;
        #1 s = {6'h0, tx_wr_stb};
        @(negedge clk);
        bus_wr = 1'b0;
        check("R10 strobe ch1", s, 8'h02);
    endtask

    task automatic t_hold_and_iack();
        logic [7:0] d;
        clear_src();
        bus_write(3'd0, 8'h00);
        set_src(0, 8'hF0, 8'h12);
        set_src(11, 8'h10, 8'h00);
        @(negedge clk);
        bus_addr = 3'd0;
        iack_n = 1'b0;
        @(posedge clk); #1 check("R3 edge 1 not yet", bus_rdata, 8'h00);
        @(posedge clk); #1 check("R3 edge 2 not yet", bus_rdata, 8'h00);
        @(posedge clk); #1 check("R3 edge 3 captured", bus_rdata, 8'h20);
        expect_capture("R3 model");
        clear_src();
        set_src(7, 8'hFF, 8'h00);
        @(negedge clk);
        iack_n = 1'b1;
        repeat (6) @(negedge clk);
        bus_read(3'd0, d); check("R8 R3 hold across rise", d, 8'h20);
        bus_read(3'd2, d); check("R8 count held", d, 8'h12);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_update_basic();
        t_tie();
        t_threshold();
        t_thr_zero();
        t_none();
        t_global();
        t_hold_and_iack();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule